// File: doc/BRIEF.md
# UART Interrupt Mask and Request Router

This block keeps the interrupt enable mask of a UART and turns the UART's raw events into request lines. The three events are receive buffer full, transmit buffer empty and line status. Software cannot write the mask directly. It changes the mask in two ways: a write of ones to a set address turns the matching enables on, and a write of ones to a clear address turns them off. A read from either address returns the current mask.

The block drives three request outputs: receive, transmit and status. The receive and transmit lines can also serve as DMA requests. The status line always goes to the interrupt controller. When no DMA channels are assigned, setting the line-status enable bit moves the masked receive and transmit requests onto the status line. In that mode the dedicated receive and transmit lines stay low.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the mask is all zero. As a result, rdata_o reads 0 and all three request outputs are low, whatever the event inputs do.
- R2: A write to SET_ADDR sets each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. The new mask is visible after the clock edge that takes the write.
- R3: A write to CLR_ADDR clears each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. The new mask is visible after the clock edge that takes the write.
- R4: The mask has three bits: bit 0 enables receive-full, bit 1 enables transmit-empty and bit 2 enables line status. A read with addr_i equal to SET_ADDR or CLR_ADDR returns the mask in bits 2:0, with every higher bit 0. Any other address reads 0.
- R5: While mask bit 2 is 0, rx_req_o equals rx_full_i AND mask bit 0.
- R6: While mask bit 2 is 0, tx_req_o equals tx_empty_i AND mask bit 1.
- R7: stat_req_o equals mask bit 2 AND the OR of three terms: line_stat_i, rx_full_i AND mask bit 0, and tx_empty_i AND mask bit 1.
- R8: While mask bit 2 is 1, rx_req_o and tx_req_o are held low.
- R9: A write to any address other than SET_ADDR or CLR_ADDR leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data (combinational) |
| rx_full_i | input | 1 | Raw receive-buffer-full event |
| tx_empty_i | input | 1 | Raw transmit-buffer-empty event |
| line_stat_i | input | 1 | Raw line-status event |
| rx_req_o | output | 1 | Receive request, also usable as a DMA request |
| tx_req_o | output | 1 | Transmit request, also usable as a DMA request |
| stat_req_o | output | 1 | Status interrupt request |

## Verification
Assertions check on every cycle that a set write or a clear write changes only the bits it names, and that writes to other addresses leave the mask unchanged. They also check that the data request lines stay silent while rerouting is on, and that a status request never appears without the line-status enable. Several things can only be shown by the bench's scenarios: that a request really appears when its event and enable are both present, that rerouted receive and transmit events reach the status line, that both addresses read back the same zero-extended mask, and that reset empties the mask part way through a run.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned MASK_W = 3;
  localparam int unsigned EN_RX  = 0;
  localparam int unsigned EN_TX  = 1;
  localparam int unsigned EN_LS  = 2;

  typedef logic [MASK_W-1:0] irq_mask_t;
endpackage

// File: rtl/uart_irq_mask_reg.sv
module uart_irq_mask_reg
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SET_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 4'h4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output irq_mask_t         mask_o
);
  localparam int unsigned PAD_W = DATA_W - MASK_W;

  irq_mask_t mask_q, mask_d;
  logic      hit_set, hit_clr;
  irq_mask_t wbits;

  assign hit_set = addr_i == SET_ADDR;
  assign hit_clr = addr_i == CLR_ADDR;
  assign wbits   = wdata_i[MASK_W-1:0];

  always_comb begin
    mask_d = mask_q;
    if (we_i && hit_set) mask_d = mask_q | wbits;
    else if (we_i && hit_clr) mask_d = mask_q & ~wbits;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign rdata_o = (hit_set || hit_clr) ? {{PAD_W{1'b0}}, mask_q} : '0;
  assign mask_o  = mask_q;

  // R2
  a_r2_set_only_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_set) |=> (mask_q == ($past(mask_q) | $past(wbits))));
  // R3
  a_r3_clr_only_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_clr) |=> (mask_q == ($past(mask_q) & ~$past(wbits))));
  // R9
  a_r9_other_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (hit_set || hit_clr)) |=> $stable(mask_q));
endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route
  import uart_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  irq_mask_t mask_i,
  input  logic      rx_full_i,
  input  logic      tx_empty_i,
  input  logic      line_stat_i,
  output logic      rx_req_o,
  output logic      tx_req_o,
  output logic      stat_req_o
);
  logic rx_m, tx_m, ls_m, reroute;

  assign reroute = mask_i[EN_LS];
  assign rx_m    = rx_full_i  & mask_i[EN_RX];
  assign tx_m    = tx_empty_i & mask_i[EN_TX];
  assign ls_m    = line_stat_i & mask_i[EN_LS];

  assign rx_req_o   = rx_m & ~reroute;
  assign tx_req_o   = tx_m & ~reroute;
  assign stat_req_o = ls_m | (reroute & (rx_m | tx_m));

  // R8
  a_r8_data_quiet_on_reroute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i[EN_LS] |-> !(rx_req_o || tx_req_o));
  // R7
  a_r7_stat_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_req_o |-> mask_i[EN_LS]);
  // R5
  a_r5_rx_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_req_o |-> (rx_full_i && mask_i[EN_RX]));
  // R6
  a_r6_tx_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> (tx_empty_i && mask_i[EN_TX]));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SET_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 4'h4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_full_i,
  input  logic              tx_empty_i,
  input  logic              line_stat_i,
  output logic              rx_req_o,
  output logic              tx_req_o,
  output logic              stat_req_o
);
  irq_mask_t mask;

  uart_irq_mask_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)
  ) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .mask_o(mask)
  );

  uart_irq_route u_route (
    .clk_i(clk_i), .rst_ni(rst_ni), .mask_i(mask),
    .rx_full_i(rx_full_i), .tx_empty_i(tx_empty_i), .line_stat_i(line_stat_i),
    .rx_req_o(rx_req_o), .tx_req_o(tx_req_o), .stat_req_o(stat_req_o)
  );

  // R1: no request while in reset
  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !(rx_req_o || tx_req_o || stat_req_o));
endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  localparam logic [3:0] SA = 4'h0;
  localparam logic [3:0] CA = 4'h4;
  localparam logic [3:0] XA = 4'h8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = SA;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rx_full_i = 1'b1, tx_empty_i = 1'b1, line_stat_i = 1'b1;
  logic        rx_req_o, tx_req_o, stat_req_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  uart_irq_ctrl u_uart_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rx_full_i(rx_full_i),
    .tx_empty_i(tx_empty_i), .line_stat_i(line_stat_i), .rx_req_o(rx_req_o),
    .tx_req_o(tx_req_o), .stat_req_o(stat_req_o)
  );

  // [16] we [15:12] addr [11:9] wdata [8:6] events {ls,tx,rx}
  // [5:3] expected mask  [2:0] expected requests {stat,tx,rx}
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, SA, 3'b001, 3'b001, 3'b001, 3'b001}, // R2 R5
    {1'b1, SA, 3'b010, 3'b011, 3'b011, 3'b011}, // R2 R6
    {1'b1, SA, 3'b000, 3'b010, 3'b011, 3'b010}, // R2 zero bits
    {1'b1, XA, 3'b111, 3'b011, 3'b011, 3'b011}, // R9
    {1'b1, CA, 3'b001, 3'b011, 3'b010, 3'b010}, // R3
    {1'b1, SA, 3'b100, 3'b010, 3'b110, 3'b100}, // R7 R8 tx rerouted
    {1'b0, SA, 3'b000, 3'b001, 3'b110, 3'b000}, // R7 rx masked
    {1'b1, SA, 3'b001, 3'b001, 3'b111, 3'b100}, // R7 R8 rx rerouted
    {1'b0, SA, 3'b000, 3'b100, 3'b111, 3'b100}, // R7 line status
    {1'b0, SA, 3'b000, 3'b000, 3'b111, 3'b000}, // R7 no events
    {1'b1, CA, 3'b100, 3'b011, 3'b011, 3'b011}, // R3 R5 R6 reroute off
    {1'b1, CA, 3'b000, 3'b100, 3'b011, 3'b000}, // R3 zero bits, R7
    {1'b1, CA, 3'b111, 3'b111, 3'b000, 3'b000}  // R3 clear all
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = SA;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, events all high
    #10;
    check("R1 rdata in reset", rdata_o, 32'h0);
    check("R1 requests in reset", {29'h0, stat_req_o, tx_req_o, rx_req_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 requests after reset", {29'h0, stat_req_o, tx_req_o, rx_req_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      we_i = VEC[i][16]; addr_i = VEC[i][15:12]; wdata_i = {29'h0, VEC[i][11:9]};
      {line_stat_i, tx_empty_i, rx_full_i} = VEC[i][8:6];
      @(negedge clk_i);
      we_i = 1'b0; addr_i = SA;
      #1;
      check($sformatf("R2 R3 R9 mask vec %0d", i), rdata_o, {29'h0, VEC[i][5:3]});
      check($sformatf("R5 R6 R7 R8 requests vec %0d", i),
            {29'h0, stat_req_o, tx_req_o, rx_req_o}, {29'h0, VEC[i][2:0]});
    end

    // R4: upper write bits ignored, both addresses read the mask, others read 0
    wr(SA, 32'hFFFF_FFFF);
    addr_i = CA; #1;
    check("R4 read via clear address", rdata_o, 32'h7);
    addr_i = SA; #1;
    check("R4 read via set address", rdata_o, 32'h7);
    addr_i = XA; #1;
    check("R4 other address reads zero", rdata_o, 32'h0);
    addr_i = SA;

    // R8: rerouted with all events, data lines quiet
    {line_stat_i, tx_empty_i, rx_full_i} = 3'b011; #1;
    check("R8 data lines low while rerouted", {29'h0, stat_req_o, tx_req_o, rx_req_o}, 32'h4);

    // R1: mid-run reset clears mask
    @(negedge clk_i); rst_ni = 1'b0; #1;
    check("R1 mask cleared by reset", rdata_o, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    {line_stat_i, tx_empty_i, rx_full_i} = 3'b111; #1;
    check("R1 requests masked after reset", {29'h0, stat_req_o, tx_req_o, rx_req_o}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule